// File: doc/BRIEF.md
# Masked Binary Match Table With Entry Validity

This block is a small associative table. Each slot holds a 64-bit word and one validity bit. A compare operation checks a 64-bit search key against every valid slot at the same time. The check can leave out some bit positions through a selectable mask. The block returns the lowest matching slot number, a hit flag, and the full per-slot match vector. Search latency is one clock cycle whatever the occupancy, and wherever the matching slot sits.

Slots are maintained in several ways. A write can go to a given slot. A write can also go to the lowest empty slot. A slot can be deleted by number, or the lowest slot that matches a key can be deleted. Each of these operations reports the slot it touched on the result index. A controller can therefore update a companion data table at the same position in the same step. A read returns a slot's stored word and its validity bit.

Operations are issued with an enable strobe. All results are registered and hold their value while the strobe is low. The validity vector and the last match vector are brought out as raw vectors, so that external flag logic can use them.

Top module: `cam_table`

## Requirements
- R1: After reset every validity bit is 0, res_idx is all ones, res_hit is 0, rd_data, rd_valid and match_vec are 0, and all seven mask registers are 0 (no bits ignored).
- R2: An operation runs only on a clock edge where op_en is 1. Results appear after that edge. op_code 1 (write) stores entry_data in slot entry_idx and sets that slot valid. It then reports res_idx = entry_idx with res_hit = 1.
- R3: op_code 6 (compare) sets match_vec bit j for each valid slot j whose stored word equals cmp_data on every non-ignored bit. It reports the lowest such j on res_idx with res_hit = 1.
- R4: A compare or match-delete that finds no matching slot reports res_idx all ones with res_hit = 0. Whenever res_hit is 0, res_idx is all ones.
- R5: A slot whose validity bit is 0 never matches, whatever word it still stores.
- R6: mask_sel 0 compares all 64 bits. mask_sel k (1 to 7) ignores every bit that is 1 in mask register k. op_code 7 loads entry_data into mask register mask_sel (mask_sel 0 is a no-op) and leaves the results unchanged.
- R7: op_code 2 (write-free) stores entry_data in the lowest slot that is not valid, sets it valid, and reports that slot with res_hit = 1. When every slot is valid, it changes nothing in the table and reports all ones with res_hit = 0.
- R8: op_code 4 (delete) clears the validity bit of slot entry_idx and reports res_idx = entry_idx with res_hit = 1.
- R9: op_code 5 (match-delete) compares like op_code 6 and updates match_vec. It then clears the validity bit of the lowest matching slot only, and reports that slot.
- R10: op_code 3 (read) puts the stored word of slot entry_idx on rd_data and its validity bit on rd_valid. It reports res_idx = entry_idx with res_hit = 1. The table is not changed.
- R11: While op_en is 0, nothing changes: neither the table, the masks nor any output. op_code 0 (no-op) with op_en 1 also changes nothing.
- R12: valid_vec bit j always equals the validity bit of slot j. rd_data, rd_valid and match_vec change only on read and on compare or match-delete respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_en | input | 1 | Operation strobe; results update only when high |
| op_code | input | 3 | Operation select (0 no-op, 1 write, 2 write-free, 3 read, 4 delete, 5 match-delete, 6 compare, 7 load mask) |
| entry_idx | input | IDX_W (4) | Slot number for write, read and delete |
| entry_data | input | ENTRY_W (64) | Word to store, or mask value to load |
| cmp_data | input | ENTRY_W (64) | Search key |
| mask_sel | input | MSEL_W (3) | Mask choice for compares, or target register for load |
| res_idx | output | IDX_W (4) | Reported slot number, all ones on a miss |
| res_hit | output | 1 | Reported slot is meaningful |
| rd_data | output | ENTRY_W (64) | Word from the last read |
| rd_valid | output | 1 | Validity bit from the last read |
| match_vec | output | DEPTH (16) | Per-slot matches of the last compare or match-delete |
| valid_vec | output | DEPTH (16) | Current validity bits |

## Verification
Compares are run against a table filled from a small pool of words, so that single, multiple and absent matches all occur. Multiple matches show whether the lowest index wins. Absent matches show the all-ones miss code. Keys that differ only in masked bits separate a working mask from a full compare. Deleted slots that still hold a matching word separate validity gating from a plain data compare. Directed sequences also fill the table through write-free until it is full, strobe operations with op_en low, and delete by match to show that only one of several equal slots is cleared.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
   typedef enum logic [2:0] {
      CAM_NOP        = 3'd0,
      CAM_WRITE      = 3'd1,
      CAM_WRITE_FREE = 3'd2,
      CAM_READ       = 3'd3,
      CAM_DELETE     = 3'd4,
      CAM_DEL_MATCH  = 3'd5,
      CAM_COMPARE    = 3'd6,
      CAM_LOAD_MASK  = 3'd7
   } cam_op_e;
endpackage

// File: rtl/cam_mask_bank.sv
`timescale 1ns/1ps
module cam_mask_bank #(
   parameter int ENTRY_W   = 64,
   parameter int NUM_MASKS = 7,
   parameter int MSEL_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [MSEL_W-1:0]  load_sel,
   input  logic [ENTRY_W-1:0] load_data,
   input  logic [MSEL_W-1:0]  use_sel,
   output logic [ENTRY_W-1:0] ignore_bits
);
   logic [NUM_MASKS:0][ENTRY_W-1:0] bank;

   // slot 0 is the fixed "compare everything" mask
   assign bank[0] = '0;

   generate
      for (genvar m = 1; m <= NUM_MASKS; m++) begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bank[m] <= '0;
            else if (load_en && (load_sel == MSEL_W'(m)))
               bank[m] <= load_data;
         end
      end
   endgenerate

   always_comb begin
      ignore_bits = '0;
      for (int m = 0; m <= NUM_MASKS; m++)
         if (use_sel == MSEL_W'(m)) ignore_bits = bank[m];
   end
endmodule

// File: rtl/cam_match_array.sv
`timescale 1ns/1ps
module cam_match_array #(
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 64
) (
   input  logic [DEPTH-1:0][ENTRY_W-1:0] entries,
   input  logic [DEPTH-1:0]              valid,
   input  logic [ENTRY_W-1:0]            key,
   input  logic [ENTRY_W-1:0]            ignore_bits,
   output logic [DEPTH-1:0]              hits
);
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         logic [ENTRY_W-1:0] diff;
         assign diff    = (entries[e] ^ key) & ~ignore_bits;
         assign hits[e] = valid[e] & ~(|diff);
      end
   endgenerate
endmodule

// File: rtl/cam_prio_enc.sv
`timescale 1ns/1ps
module cam_prio_enc #(
   parameter int WIDTH     = 16,
   parameter int IDX_W     = 4,
   parameter int ENC_STYLE = 1
) (
   input  logic [WIDTH-1:0] req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   logic [IDX_W-1:0] raw_idx;

   assign any = |req;
   assign idx = any ? raw_idx : '1;

   generate
      if (ENC_STYLE == 0) begin : g_linear
         always_comb begin
            raw_idx = '0;
            for (int i = WIDTH - 1; i >= 0; i--)
               if (req[i]) raw_idx = IDX_W'(i);
         end
      end else begin : g_isolate
         logic [WIDTH-1:0] lowest;
         assign lowest = req & (~req + WIDTH'(1));
         always_comb begin
            raw_idx = '0;
            for (int i = 0; i < WIDTH; i++)
               if (lowest[i]) raw_idx = raw_idx | IDX_W'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/cam_table.sv
`timescale 1ns/1ps
module cam_table
   import cam_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int ENTRY_W   = 64,
   parameter int NUM_MASKS = 7,
   parameter int ENC_STYLE = 1,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int MSEL_W   = $clog2(NUM_MASKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_en,
   input  logic [2:0]         op_code,
   input  logic [IDX_W-1:0]   entry_idx,
   input  logic [ENTRY_W-1:0] entry_data,
   input  logic [ENTRY_W-1:0] cmp_data,
   input  logic [MSEL_W-1:0]  mask_sel,
   output logic [IDX_W-1:0]   res_idx,
   output logic               res_hit,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               rd_valid,
   output logic [DEPTH-1:0]   match_vec,
   output logic [DEPTH-1:0]   valid_vec
);
   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("cam_table: DEPTH must be a power of two of at least 2");
      end
      if (NUM_MASKS < 1) begin : g_bad_masks
         $error("cam_table: NUM_MASKS must be at least 1");
      end
      if (ENTRY_W < 1) begin : g_bad_width
         $error("cam_table: ENTRY_W must be positive");
      end
      if (ENC_STYLE != 0 && ENC_STYLE != 1) begin : g_bad_style
         $error("cam_table: ENC_STYLE must be 0 or 1");
      end
   endgenerate

   cam_op_e op;
   assign op = cam_op_e'(op_code);

   logic [DEPTH-1:0][ENTRY_W-1:0] ent_q;
   logic [DEPTH-1:0]              vld_q;
   logic [ENTRY_W-1:0]            ignore_bits;
   logic [DEPTH-1:0]              hits;
   logic [IDX_W-1:0]              hit_idx, free_idx;
   logic                          hit_any, free_any;

   logic go_write, go_free, go_read, go_del, go_mdel, go_cmp, go_load;
   assign go_write = op_en && (op == CAM_WRITE);
   assign go_free  = op_en && (op == CAM_WRITE_FREE);
   assign go_read  = op_en && (op == CAM_READ);
   assign go_del   = op_en && (op == CAM_DELETE);
   assign go_mdel  = op_en && (op == CAM_DEL_MATCH);
   assign go_cmp   = op_en && (op == CAM_COMPARE);
   assign go_load  = op_en && (op == CAM_LOAD_MASK);

   cam_mask_bank #(
      .ENTRY_W  (ENTRY_W),
      .NUM_MASKS(NUM_MASKS),
      .MSEL_W   (MSEL_W)
   ) u_masks (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (go_load),
      .load_sel   (mask_sel),
      .load_data  (entry_data),
      .use_sel    (mask_sel),
      .ignore_bits(ignore_bits)
   );

   cam_match_array #(
      .DEPTH  (DEPTH),
      .ENTRY_W(ENTRY_W)
   ) u_match (
      .entries    (ent_q),
      .valid      (vld_q),
      .key        (cmp_data),
      .ignore_bits(ignore_bits),
      .hits       (hits)
   );

   cam_prio_enc #(
      .WIDTH    (DEPTH),
      .IDX_W    (IDX_W),
      .ENC_STYLE(ENC_STYLE)
   ) u_hit_enc (
      .req(hits),
      .idx(hit_idx),
      .any(hit_any)
   );

   cam_prio_enc #(
      .WIDTH    (DEPTH),
      .IDX_W    (IDX_W),
      .ENC_STYLE(ENC_STYLE)
   ) u_free_enc (
      .req(~vld_q),
      .idx(free_idx),
      .any(free_any)
   );

   // stored words carry no reset: validity alone decides their use
   always_ff @(posedge clk) begin
      if (go_write)
         ent_q[entry_idx] <= entry_data;
      else if (go_free && free_any)
         ent_q[free_idx] <= entry_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (go_write)              vld_q[entry_idx] <= 1'b1;
         if (go_free && free_any)   vld_q[free_idx]  <= 1'b1;
         if (go_del)                vld_q[entry_idx] <= 1'b0;
         if (go_mdel && hit_any)    vld_q[hit_idx]   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_idx   <= '1;
         res_hit   <= 1'b0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         match_vec <= '0;
      end else begin
         if (go_write || go_read || go_del) begin
            res_idx <= entry_idx;
            res_hit <= 1'b1;
         end
         if (go_free) begin
            res_idx <= free_idx;
            res_hit <= free_any;
         end
         if (go_cmp || go_mdel) begin
            res_idx   <= hit_idx;
            res_hit   <= hit_any;
            match_vec <= hits;
         end
         if (go_read) begin
            rd_data  <= ent_q[entry_idx];
            rd_valid <= vld_q[entry_idx];
         end
      end
   end

   assign valid_vec = vld_q;
endmodule

// File: rtl/cam_table_chk.sv
`timescale 1ns/1ps
module cam_table_chk
   import cam_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 64,
   parameter int IDX_W   = 4,
   parameter int MSEL_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_en,
   input logic [2:0]         op_code,
   input logic [IDX_W-1:0]   entry_idx,
   input logic [ENTRY_W-1:0] entry_data,
   input logic [ENTRY_W-1:0] cmp_data,
   input logic [MSEL_W-1:0]  mask_sel,
   input logic [IDX_W-1:0]   res_idx,
   input logic               res_hit,
   input logic [ENTRY_W-1:0] rd_data,
   input logic               rd_valid,
   input logic [DEPTH-1:0]   match_vec,
   input logic [DEPTH-1:0]   valid_vec
);
   a_r4_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_idx == '1));

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> ($stable(res_idx) && $stable(res_hit) && $stable(valid_vec)
                  && $stable(match_vec) && $stable(rd_data)));

   a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_WRITE) |=>
         (valid_vec[$past(entry_idx)] && res_hit && res_idx == $past(entry_idx)));

   a_r8_delete_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_DELETE) |=>
         (!valid_vec[$past(entry_idx)] && res_idx == $past(entry_idx)));

   a_r5_match_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_COMPARE) |=> ((match_vec & ~$past(valid_vec)) == '0));

   a_r3_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_COMPARE) |=>
         (res_hit == (match_vec != '0)) && (!res_hit || match_vec[res_idx]));

   a_r7_full_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_WRITE_FREE && (&valid_vec)) |=>
         (!res_hit && valid_vec == $past(valid_vec)));

   a_r9_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op_code == CAM_DEL_MATCH) |=>
         ($countones($past(valid_vec) & ~valid_vec) <= 1));
endmodule

bind cam_table cam_table_chk #(
   .DEPTH  (DEPTH),
   .ENTRY_W(ENTRY_W),
   .IDX_W  (IDX_W),
   .MSEL_W (MSEL_W)
) u_chk (.*);

// File: tb/cam_table_tb.sv
`timescale 1ns/1ps
module cam_table_tb;
   import cam_pkg::*;

   localparam int DEPTH = 16;
   localparam int EW    = 64;
   localparam int IW    = 4;
   localparam int MW    = 3;
   localparam int NM    = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_en = 1'b0;
   logic [2:0]    op_code = 3'd0;
   logic [IW-1:0] entry_idx = '0;
   logic [EW-1:0] entry_data = '0;
   logic [EW-1:0] cmp_data = '0;
   logic [MW-1:0] mask_sel = '0;
   logic [IW-1:0] res_idx;
   logic          res_hit;
   logic [EW-1:0] rd_data;
   logic          rd_valid;
   logic [DEPTH-1:0] match_vec, valid_vec;

   always #4 clk = ~clk;

   cam_table u_dut (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
      .entry_idx(entry_idx), .entry_data(entry_data), .cmp_data(cmp_data),
      .mask_sel(mask_sel), .res_idx(res_idx), .res_hit(res_hit),
      .rd_data(rd_data), .rd_valid(rd_valid), .match_vec(match_vec),
      .valid_vec(valid_vec)
   );

   int checks = 0;
   int failures = 0;

   // reference state
   logic [EW-1:0]    m_data [DEPTH];
   logic [DEPTH-1:0] m_vld;
   logic [EW-1:0]    m_mask [NM+1];
   logic [IW-1:0]    e_idx;
   logic             e_hit;
   logic [EW-1:0]    e_rd;
   logic             e_rdv;
   logic [DEPTH-1:0] e_match;
   logic [EW-1:0]    pool [6];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DEPTH-1:0] ref_match(input logic [EW-1:0] key,
                                                  input logic [MW-1:0] sel);
      logic [DEPTH-1:0] r = '0;
      logic [EW-1:0] ign = (sel == 0) ? '0 : m_mask[sel];
      for (int j = 0; j < DEPTH; j++)
         r[j] = m_vld[j] && (((m_data[j] ^ key) & ~ign) == '0);
      return r;
   endfunction

   function automatic int lowest(input logic [DEPTH-1:0] v);
      for (int j = 0; j < DEPTH; j++) if (v[j]) return j;
      return -1;
   endfunction

   task automatic ref_apply(input logic [2:0] op, input logic [IW-1:0] idx,
                            input logic [EW-1:0] d, input logic [EW-1:0] key,
                            input logic [MW-1:0] sel);
      int j;
      logic [DEPTH-1:0] mv;
      case (op)
         CAM_WRITE: begin m_data[idx] = d; m_vld[idx] = 1'b1; e_idx = idx; e_hit = 1'b1; end
         CAM_WRITE_FREE: begin
            j = lowest(~m_vld);
            if (j >= 0) begin m_data[j] = d; m_vld[j] = 1'b1; e_idx = IW'(j); e_hit = 1'b1; end
            else begin e_idx = '1; e_hit = 1'b0; end
         end
         CAM_READ: begin e_rd = m_data[idx]; e_rdv = m_vld[idx]; e_idx = idx; e_hit = 1'b1; end
         CAM_DELETE: begin m_vld[idx] = 1'b0; e_idx = idx; e_hit = 1'b1; end
         CAM_DEL_MATCH, CAM_COMPARE: begin
            mv = ref_match(key, sel);
            e_match = mv;
            j = lowest(mv);
            if (j >= 0) begin
               e_idx = IW'(j); e_hit = 1'b1;
               if (op == CAM_DEL_MATCH) m_vld[j] = 1'b0;
            end else begin e_idx = '1; e_hit = 1'b0; end
         end
         CAM_LOAD_MASK: if (sel != 0) m_mask[sel] = d;
         default: ;
      endcase
   endtask

   task automatic check_all(input string tag);
      chk(res_idx == e_idx, tag, "res_idx", EW'(res_idx), EW'(e_idx));
      chk(res_hit == e_hit, tag, "res_hit", EW'(res_hit), EW'(e_hit));
      chk(valid_vec == m_vld, "R12", "valid_vec", EW'(valid_vec), EW'(m_vld));
      chk(match_vec == e_match, tag, "match_vec", EW'(match_vec), EW'(e_match));
      chk(rd_data == e_rd && rd_valid == e_rdv, tag, "rd_data/rd_valid",
          {rd_data[EW-2:0], rd_valid}, {e_rd[EW-2:0], e_rdv});
   endtask

   // drive at negedge, result visible after the next posedge, sampled at the following negedge
   task automatic run_op(input logic en, input logic [2:0] op, input logic [IW-1:0] idx,
                         input logic [EW-1:0] d, input logic [EW-1:0] key,
                         input logic [MW-1:0] sel, input string tag);
      @(negedge clk);
      op_en = en; op_code = op; entry_idx = idx; entry_data = d;
      cmp_data = key; mask_sel = sel;
      @(posedge clk);
      @(negedge clk);
      op_en = 1'b0; op_code = 3'd0;
      if (en) ref_apply(op, idx, d, key, sel);
      check_all(tag);
   endtask

   initial begin
      #(8 * 150000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [EW-1:0] A, B;
      void'($urandom(32'h0C0FFEE5));
      for (int j = 0; j < DEPTH; j++) m_data[j] = '0;
      for (int k = 0; k <= NM; k++) m_mask[k] = '0;
      m_vld = '0; e_idx = '1; e_hit = 0; e_rd = '0; e_rdv = 0; e_match = '0;
      for (int k = 0; k < 6; k++) pool[k] = {$urandom, $urandom};
      A = 64'hDEAD_BEEF_0123_4567;
      B = 64'h1111_2222_3333_4444;

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");                                       // reset state

      run_op(1, CAM_COMPARE, 0, 0, A, 0, "R4");              // empty table misses
      run_op(1, CAM_WRITE, 3, A, 0, 0, "R2");
      run_op(1, CAM_WRITE, 7, A, 0, 0, "R2");
      run_op(1, CAM_COMPARE, 0, 0, A, 0, "R3");              // slots 3 and 7, lowest 3
      run_op(1, CAM_WRITE, 1, A ^ 64'hFF, 0, 0, "R2");
      run_op(1, CAM_COMPARE, 0, 0, A, 3, "R1");              // mask 3 still zero: slot 1 misses
      run_op(1, CAM_LOAD_MASK, 0, 64'hFF, 0, 2, "R6");
      run_op(1, CAM_COMPARE, 0, 0, A, 2, "R6");              // low byte ignored: slot 1 wins
      run_op(1, CAM_COMPARE, 0, 0, A, 0, "R6");              // full compare: slot 3
      run_op(1, CAM_LOAD_MASK, 0, '1, 0, 0, "R6");           // sel 0 load is a no-op
      run_op(1, CAM_COMPARE, 0, 0, B, 0, "R6");
      run_op(1, CAM_DELETE, 3, 0, 0, 0, "R8");
      run_op(1, CAM_COMPARE, 0, 0, A, 0, "R5");              // deleted slot 3 keeps word, no match
      run_op(1, CAM_READ, 3, 0, 0, 0, "R10");                // word A, validity 0
      run_op(1, CAM_READ, 7, 0, 0, 0, "R10");
      run_op(0, CAM_WRITE, 9, B, 0, 0, "R11");               // strobe low: nothing
      run_op(0, CAM_DELETE, 7, 0, 0, 0, "R11");
      run_op(1, CAM_NOP, 7, B, B, 0, "R11");
      run_op(1, CAM_COMPARE, 0, 0, B, 0, "R11");             // slot 9 never written
      run_op(1, CAM_DEL_MATCH, 0, 0, A, 2, "R9");            // slots 1,7 match; 1 cleared
      run_op(1, CAM_COMPARE, 0, 0, A, 2, "R9");
      run_op(1, CAM_DEL_MATCH, 0, 0, B, 0, "R9");            // miss: all ones
      for (int k = 0; k < DEPTH + 1; k++)
         run_op(1, CAM_WRITE_FREE, 0, B + EW'(k), 0, 0, "R7"); // fills, then full
      run_op(1, CAM_COMPARE, 0, 0, B, 0, "R3");
      for (int k = 0; k < DEPTH; k++)
         run_op(1, CAM_DELETE, IW'(k), 0, 0, 0, "R8");

      for (int n = 0; n < 600; n++) begin
         logic [2:0] op;
         logic [EW-1:0] d, key;
         int r = $urandom % 20;
         if (r < 5) op = CAM_WRITE;
         else if (r < 7) op = CAM_WRITE_FREE;
         else if (r < 9) op = CAM_READ;
         else if (r < 11) op = CAM_DELETE;
         else if (r < 13) op = CAM_DEL_MATCH;
         else if (r < 18) op = CAM_COMPARE;
         else if (r < 19) op = CAM_LOAD_MASK;
         else op = CAM_NOP;
         d = pool[$urandom % 6];
         key = pool[$urandom % 6] ^ ((($urandom % 3) == 0) ? EW'($urandom % 256) : '0);
         if (op == CAM_LOAD_MASK) d = {$urandom, $urandom} & {$urandom, $urandom};
         run_op(($urandom % 8) != 0, op, IW'($urandom), d, key, MW'($urandom), "R3");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule